// File: doc/BRIEF.md
# UART Receive Character Queue with Status

This block sits behind the bit-level deserializer of a UART receiver. Each finished character arrives as a one-cycle strobe with its data byte and three error flags: parity, framing and break. A separate strobe marks each detected start bit. Characters wait in a three-entry queue. A single holding stage behind the queue acts as a fourth slot. When a character arrives while the holding stage is still occupied, the held character is lost.

The CPU side is a valid/ready read port. `rd_valid` is high while the queue holds a character, and a character leaves only on a cycle where `rd_valid` and `rd_ready` are both high. The incoming character stream cannot be stalled, because a serial line cannot wait. Back-pressure toward the remote sender is therefore applied through the automatic RTS output.

The status vector can be read at any time without side effects. Its error bits run in one of two modes. In per-character mode they show the errors of the character at the head of the queue. In block mode they show the OR of the errors of every character that has reached the head since the last error-reset command. Command strobes enable, disable and reset the receiver, and clear the error status.

Top module: `uart_rx_queue`

## Requirements
- R1: While the receiver is on, each `chr_valid` strobe enqueues one character. Characters leave through `rd_data` in arrival order, one per cycle in which `rd_valid` and `rd_ready` are both high. `rd_valid` is high exactly while the queue is non-empty.
- R2: `status[0]` is high while the queue is non-empty. `status[1]` is high while all three queue entries are occupied.
- R3: A character that completes while the queue is full and nothing is being read waits in the holding stage. It enters the queue in the same cycle as the next read.
- R4: A character that completes while the holding stage is occupied, with the queue full and no read, replaces the held character. The queued characters do not change.
- R5: `status[2]` (overrun) is set in the cycle after a `start_det` strobe that sees the holding stage occupied and the queue full with no read. It stays set until `cmd_err_rst` or `cmd_rx_rst`.
- R6: When `blk_mode` is 0, `status[3]`, `status[4]` and `status[5]` show the parity, framing and break flags (`chr_err` bits 0, 1 and 2) of the head character. All three are 0 when the queue is empty.
- R7: When `blk_mode` is 1, the same three bits show the OR of the flags of every character that became head since the last `cmd_err_rst`. They update as each character becomes head, and `cmd_err_rst` clears them.
- R8: Watching `status` changes nothing. While `rd_ready` is low, the head character and `rd_data` stay put.
- R9: With `auto_rts` high, `rts_o` falls after a `start_det` strobe that sees the queue full with no read. It rises again after the next read. With `auto_rts` low, `rts_o` stays high.
- R10: `cmd_rx_rst` empties the queue and the holding stage, clears all status bits, and drives `rts_o` high and `irq_o` low. It also turns the receiver off, so no character is accepted until `cmd_rx_en`.
- R11: After `cmd_rx_dis`, incoming characters and start strobes are ignored. Characters already queued can still be read.
- R12: `irq_o` is high exactly while the queue is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_rx_en | input | 1 | Receiver-on command strobe |
| cmd_rx_dis | input | 1 | Receiver-off command strobe; the queue is kept |
| cmd_rx_rst | input | 1 | Receiver reset command strobe |
| cmd_err_rst | input | 1 | Error-status clear command strobe |
| blk_mode | input | 1 | 1 selects cumulative block-mode error reporting |
| auto_rts | input | 1 | 1 enables automatic RTS flow control |
| start_det | input | 1 | Start bit detected strobe |
| chr_valid | input | 1 | Character complete strobe |
| chr_data | input | DATA_W | Completed character |
| chr_err | input | 3 | Flags of the completed character: bit0 parity, bit1 framing, bit2 break |
| rd_valid | output | 1 | Head character available |
| rd_ready | input | 1 | CPU takes the head character |
| rd_data | output | DATA_W | Head character |
| status | output | 6 | {break, framing, parity, overrun, full, ready} |
| rts_o | output | 1 | Request-to-send, high means the sender may transmit |
| irq_o | output | 1 | Interrupt / DMA request |

## Verification
The hardest situation to reach is the overrun. The queue must be full, a character must already be waiting in the holding stage, and another start bit must then arrive before any read. The vector table builds this step by step: three characters, a start strobe, a fourth character, a second start strobe and a fifth character, all with `rd_ready` held low. The drain that follows then shows from the read data which character survived and when the overrun bit rose. Block-mode accumulation is checked in a separate directed test that lets characters with different flags become head one at a time.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int ERR_W = 3;
  localparam int ST_W  = 6;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_err_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import uart_rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  rx_err_t           push_err,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output rx_err_t           head_err,
  output logic [CNT_W-1:0]  count
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_d [DEPTH];
  rx_err_t           mem_e [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wr_ptr == PTR_W'(g)) begin
        mem_d[g] <= push_data;
        mem_e[g] <= push_err;
      end
    end
  end

  assign head_data = mem_d[rd_ptr];
  assign head_err  = mem_e[rd_ptr];
endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import uart_rxq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  logic    err_clr,
  input  logic    blk_mode,
  input  logic    head_valid,
  input  rx_err_t head_err,
  input  logic    pop,
  input  logic    ovr_set,
  output rx_err_t err_out,
  output logic    ovr
);
  rx_err_t acc;
  logic    seen;
  rx_err_t fresh;

  assign fresh = (head_valid && !seen) ? head_err : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      seen <= 1'b0;
      ovr  <= 1'b0;
    end else if (clr) begin
      acc  <= '0;
      seen <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      ovr <= (ovr && !err_clr) || ovr_set;
      if (err_clr) begin
        acc  <= '0;
        seen <= head_valid && !pop;
      end else begin
        acc <= acc | fresh;
        if (pop)             seen <= 1'b0;
        else if (head_valid) seen <= 1'b1;
      end
    end
  end

  always_comb begin
    if (blk_mode)        err_out = acc | fresh;
    else if (head_valid) err_out = head_err;
    else                 err_out = '0;
  end
endmodule

// File: rtl/rxq_rts.sv
module rxq_rts (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic auto_en,
  input  logic start_hit,
  input  logic full,
  input  logic pop,
  output logic rts_o
);
  logic neg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          neg <= 1'b0;
    else if (clr || !auto_en)            neg <= 1'b0;
    else if (start_hit && full && !pop)  neg <= 1'b1;
    else if (pop)                        neg <= 1'b0;
  end

  assign rts_o = !neg;
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rx_en,
  input  logic              cmd_rx_dis,
  input  logic              cmd_rx_rst,
  input  logic              cmd_err_rst,
  input  logic              blk_mode,
  input  logic              auto_rts,
  input  logic              start_det,
  input  logic              chr_valid,
  input  logic [DATA_W-1:0] chr_data,
  input  logic [ERR_W-1:0]  chr_err,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic [ST_W-1:0]   status,
  output logic              rts_o,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              rx_on;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  rx_err_t           hold_err;
  logic [CNT_W-1:0]  count;
  rx_err_t           head_err, err_bits, in_err, push_err;
  logic [DATA_W-1:0] push_data;
  logic              pop, full, space, take, push, ovr, ovr_set, start_hit;

  assign in_err    = rx_err_t'(chr_err);
  assign rd_valid  = (count != '0);
  assign pop       = rd_valid && rd_ready;
  assign full      = (count == CNT_W'(DEPTH));
  assign space     = !full || pop;
  assign take      = rx_on && chr_valid;
  assign start_hit = rx_on && start_det;
  assign push      = hold_full ? space : (take && space);
  assign push_data = hold_full ? hold_data : chr_data;
  assign push_err  = hold_full ? hold_err  : in_err;
  assign ovr_set   = start_hit && hold_full && !space;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        rx_on <= 1'b0;
    else if (cmd_rx_rst || cmd_rx_dis) rx_on <= 1'b0;
    else if (cmd_rx_en)                rx_on <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
    end else if (cmd_rx_rst) begin
      hold_full <= 1'b0;
    end else if (take && (hold_full || !space)) begin
      hold_full <= 1'b1;
    end else if (hold_full && space) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take && (hold_full || !space)) begin
      hold_data <= chr_data;
      hold_err  <= in_err;
    end
  end

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cmd_rx_rst),
    .push      (push),
    .push_data (push_data),
    .push_err  (push_err),
    .pop       (pop),
    .head_data (rd_data),
    .head_err  (head_err),
    .count     (count)
  );

  rxq_status status_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cmd_rx_rst),
    .err_clr    (cmd_err_rst),
    .blk_mode   (blk_mode),
    .head_valid (rd_valid),
    .head_err   (head_err),
    .pop        (pop),
    .ovr_set    (ovr_set),
    .err_out    (err_bits),
    .ovr        (ovr)
  );

  rxq_rts rts_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cmd_rx_rst),
    .auto_en   (auto_rts),
    .start_hit (start_hit),
    .full      (full),
    .pop       (pop),
    .rts_o     (rts_o)
  );

  assign status = {err_bits.brk, err_bits.frm, err_bits.par, ovr, full, rd_valid};
  assign irq_o  = rd_valid;
endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_rx_rst,
  input logic              start_det,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic [5:0]        status,
  input logic              rts_o,
  input logic              irq_o
);
  AST_FULL_HAS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> status[0]); // R2

  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !cmd_rx_rst) |=> (rd_valid && rd_data == $past(rd_data))); // R8

  AST_OVR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(start_det)); // R5

  AST_RTS_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts_o) |-> $past(start_det && status[1])); // R9

  AST_RX_RST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rx_rst |=> (status == 6'b0 && rts_o && !irq_o && !rd_valid)); // R10
endmodule

bind uart_rx_queue uart_rx_queue_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_rx_rst (cmd_rx_rst),
  .start_det  (start_det),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data),
  .status     (status),
  .rts_o      (rts_o),
  .irq_o      (irq_o)
);

// File: tb/uart_rx_queue_tb_top.sv
module uart_rx_queue_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_rx_en = 0, cmd_rx_dis = 0, cmd_rx_rst = 0, cmd_err_rst = 0;
  logic       blk_mode = 0, auto_rts = 1;
  logic       start_det = 0, chr_valid = 0, rd_ready = 0;
  logic [7:0] chr_data = 0;
  logic [2:0] chr_err = 0;
  logic       rd_valid, rts_o, irq_o;
  logic [7:0] rd_data;
  logic [5:0] status;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  uart_rx_queue dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_rx_en(cmd_rx_en), .cmd_rx_dis(cmd_rx_dis),
    .cmd_rx_rst(cmd_rx_rst), .cmd_err_rst(cmd_err_rst), .blk_mode(blk_mode),
    .auto_rts(auto_rts), .start_det(start_det), .chr_valid(chr_valid),
    .chr_data(chr_data), .chr_err(chr_err), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .status(status), .rts_o(rts_o),
    .irq_o(irq_o)
  );

  // {chr_valid, data, err, start, rd_ready, expected rd_data before edge, expected status, expected rts}
  localparam int NV = 11;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 8'h11, 3'b000, 1'b0, 1'b0, 8'h00, 6'b000001, 1'b1}, // R1 first char
    {1'b1, 8'h22, 3'b001, 1'b0, 1'b0, 8'h00, 6'b000001, 1'b1}, // R6 head clean
    {1'b1, 8'h33, 3'b000, 1'b0, 1'b0, 8'h00, 6'b000011, 1'b1}, // R2 full
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'h00, 6'b000011, 1'b0}, // R9 rts drop
    {1'b1, 8'h44, 3'b010, 1'b0, 1'b0, 8'h00, 6'b000011, 1'b0}, // R3 held
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'h00, 6'b000111, 1'b0}, // R5 overrun on start
    {1'b1, 8'h55, 3'b100, 1'b0, 1'b0, 8'h00, 6'b000111, 1'b0}, // R4 held replaced
    {1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 8'h11, 6'b001111, 1'b1}, // R3 refill on read
    {1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 8'h22, 6'b000101, 1'b1}, // R1 order
    {1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 8'h33, 6'b100101, 1'b1}, // R4 survivor 55
    {1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 8'h55, 6'b000100, 1'b1}  // R5 sticky
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, step through posedge, return at next negedge
  task automatic step(input logic cv, input logic [7:0] d, input logic [2:0] e,
                      input logic sd, input logic rdy);
    chr_valid = cv; chr_data = d; chr_err = e; start_det = sd; rd_ready = rdy;
    @(posedge clk);
    @(negedge clk);
    chr_valid = 0; start_det = 0; rd_ready = 0;
  endtask

  task automatic cmd(input int which);
    case (which)
      0: cmd_rx_en = 1;
      1: cmd_rx_dis = 1;
      2: cmd_rx_rst = 1;
      default: cmd_err_rst = 1;
    endcase
    @(posedge clk);
    @(negedge clk);
    cmd_rx_en = 0; cmd_rx_dis = 0; cmd_rx_rst = 0; cmd_err_rst = 0;
  endtask

  task automatic pop_chk(input string req, input logic [7:0] exp_d);
    chk(req, {31'b0, rd_valid}, 32'd1);
    chk(req, {24'b0, rd_data}, {24'b0, exp_d});
    step(0, 0, 0, 0, 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset status", {26'b0, status}, 32'd0);
    chk("R10 reset rts", {31'b0, rts_o}, 32'd1);
    chk("R12 reset irq", {31'b0, irq_o}, 32'd0);
    chk("R1 reset rd_valid", {31'b0, rd_valid}, 32'd0);
    cmd(0);

    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      chr_valid = v[28]; chr_data = v[27:20]; chr_err = v[19:17];
      start_det = v[16]; rd_ready = v[15];
      if (v[15]) chk($sformatf("R1 vec%0d rd_data", i), {24'b0, rd_data}, {24'b0, v[14:7]});
      @(posedge clk);
      @(negedge clk);
      chr_valid = 0; start_det = 0; rd_ready = 0;
      chk($sformatf("R2 R5 R6 vec%0d status", i), {26'b0, status}, {26'b0, v[6:1]});
      chk($sformatf("R9 vec%0d rts", i), {31'b0, rts_o}, {31'b0, v[0]});
      chk($sformatf("R12 vec%0d irq", i), {31'b0, irq_o}, {31'b0, v[1]});
    end

    // R5 overrun cleared by error reset
    cmd(3);
    chk("R5 err reset clears overrun", {26'b0, status}, 32'd0);

    // R8 holding without a read
    step(1, 8'hA6, 3'b000, 0, 0);
    step(1, 8'hB7, 3'b000, 0, 0);
    for (int k = 0; k < 3; k++) begin
      chk("R8 status unchanged", {26'b0, status}, 32'd1);
      chk("R8 head stable", {24'b0, rd_data}, 32'hA6);
      @(negedge clk);
    end
    pop_chk("R8 pop A6", 8'hA6);
    pop_chk("R8 pop B7", 8'hB7);
    chk("R1 empty after drain", {31'b0, rd_valid}, 32'd0);

    // R7 block mode accumulation
    blk_mode = 1;
    step(1, 8'h01, 3'b001, 0, 0);
    chk("R7 first head parity", {26'b0, status}, 32'b001001);
    step(1, 8'h02, 3'b010, 0, 0);
    step(1, 8'h03, 3'b000, 0, 0);
    chk("R7 full, only head counted", {26'b0, status}, 32'b001011);
    pop_chk("R7 pop 01", 8'h01);
    chk("R7 framing ORed", {26'b0, status}, 32'b011001);
    pop_chk("R7 pop 02", 8'h02);
    chk("R7 clean head keeps OR", {26'b0, status}, 32'b011001);
    pop_chk("R7 pop 03", 8'h03);
    chk("R7 empty keeps OR", {26'b0, status}, 32'b011000);
    cmd(3);
    chk("R7 err reset clears OR", {26'b0, status}, 32'd0);
    blk_mode = 0;

    // R6 character mode on empty queue
    chk("R6 empty error bits", {29'b0, status[5:3]}, 32'd0);

    // R11 disabled receiver ignores input, queue still readable
    step(1, 8'h5A, 3'b000, 0, 0);
    cmd(1);
    step(1, 8'h99, 3'b100, 0, 0);
    chk("R11 status after ignored char", {26'b0, status}, 32'd1);
    pop_chk("R11 read after disable", 8'h5A);
    chk("R11 ignored char absent", {31'b0, rd_valid}, 32'd0);

    // R10 receiver reset
    cmd(0);
    step(1, 8'hC1, 3'b011, 0, 0);
    step(1, 8'hC2, 3'b000, 0, 0);
    cmd(2);
    chk("R10 status cleared", {26'b0, status}, 32'd0);
    chk("R10 irq cleared", {31'b0, irq_o}, 32'd0);
    chk("R10 rd_valid cleared", {31'b0, rd_valid}, 32'd0);
    step(1, 8'hC3, 3'b000, 0, 0);
    chk("R10 off until enabled", {31'b0, rd_valid}, 32'd0);
    cmd(0);
    step(1, 8'hC4, 3'b000, 0, 0);
    chk("R12 irq with data", {31'b0, irq_o}, 32'd1);
    pop_chk("R10 accept after enable", 8'hC4);

    // R9 manual RTS when auto disabled
    auto_rts = 0;
    step(1, 8'hD1, 3'b000, 0, 0);
    step(1, 8'hD2, 3'b000, 0, 0);
    step(1, 8'hD3, 3'b000, 0, 0);
    step(0, 8'h00, 3'b000, 1, 0);
    chk("R9 rts stays high without auto", {31'b0, rts_o}, 32'd1);
    chk("R2 full without auto", {31'b0, status[1]}, 32'd1);
    pop_chk("R1 pop D1", 8'hD1);
    pop_chk("R1 pop D2", 8'hD2);
    pop_chk("R1 pop D3", 8'hD3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule